// File: doc/BRIEF.md
# Standard-Definition TV Sync and Burst Timing Generator

This block produces all horizontal and vertical timing strobes for an interlaced standard-definition TV output. It runs from a 13.5 MHz pixel-rate enable and selects one of two fixed rasters: 858 pixels by 525 lines (NTSC) or 864 pixels by 625 lines (PAL). A pixel counter and a line counter walk the raster. A field flag marks the second field of the frame. From these counters the block decodes horizontal sync, vertical sync, composite sync, blanking, an active-video flag and a gate that marks where the colour burst is to be placed.

Composite sync carries the vertical interval in its usual shape, but only as sync-level timing. Equalizing pulses and broad pulses with serrations are produced at half-line rate. In the 625-line raster the second field begins at the middle of a line. Two shift inputs move the active window: one moves it right in pixels and the other moves it down in lines. A change to the standard select takes effect only when the current frame ends.

Top module: `sdtv_sync_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `h_cnt` and `v_cnt` are 0, `field`, `vsync`, `burst_gate` and `active` are 0, and `hsync`, `csync` and `blank` are 1.
- R2: On each clock with `pix_en` high, `h_cnt` advances and wraps after 857 (NTSC) or 863 (PAL). `v_cnt` advances when `h_cnt` wraps and itself wraps after the last line of the frame: 524 or 624 by default. With `pix_en` low, both counters hold.
- R3: `hsync` is 1 exactly when `h_cnt` is below 64.
- R4: `burst_gate` is 1 when `h_cnt` lies in [64+B, 98+B), where B is 8 for NTSC and 12 for PAL, and 18 half-lines or more have passed since the current field started.
- R5: Horizontally, video is active for `h_cnt` in [A+`h_shift`, A+`h_shift`+720), where A is 112 for NTSC and 118 for PAL.
- R6: Let L be the line within the field: `v_cnt` in field 0, and `v_cnt` minus the first line of field 1 in field 1. Vertically, video is active for L in [V+`v_shift`, V+`v_shift`+N), where V is 20 (NTSC) or 22 (PAL) and N is 240 or 288.
- R7: `field` is 0 from frame start. It becomes 1 where field 1 starts: NTSC line 263 at pixel 0, or PAL line 312 at pixel 432.
- R8: `vsync` is 1 during half-lines 6 through 11 of each field, counted from the field start as half-line 0.
- R9: `csync` follows the vertical interval. In half-lines 0–5 and 12–17 it is a 32-pixel equalizing pulse at the start of each half-line. In half-lines 6–11 it is a broad pulse, high for the first half-line length minus 64 pixels. At other times it equals `hsync`.
- R10: `blank` is always the inverse of `active`. `active`, `burst_gate` and `csync` never overlap.
- R11: The value of `std_pal` is taken only at the frame wrap. A change in mid-frame leaves the current frame's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate enable (13.5 MHz) |
| std_pal | input | 1 | Standard select: 0 NTSC 525-line, 1 PAL 625-line |
| h_shift | input | H_SHIFT_W | Active window shift right, in pixels |
| v_shift | input | V_SHIFT_W | Active window shift down, in lines |
| h_cnt | output | CNT_W | Pixel counter |
| v_cnt | output | CNT_W | Line counter |
| field | output | 1 | 0 in the first field, 1 in the second |
| hsync | output | 1 | Horizontal sync, 1 at sync level |
| vsync | output | 1 | Vertical sync, 1 at sync level |
| csync | output | 1 | Composite sync, 1 at sync level |
| blank | output | 1 | 1 outside active video |
| active | output | 1 | 1 inside active video |
| burst_gate | output | 1 | 1 where colour burst belongs |

## Verification
Every output is a decode of three registers: the pixel count, the line count and a half-line count since the field started. A wrong value in any of them therefore shows at the ports in the same cycle. A pixel-count fault moves `hsync`, the burst gate or the active window. A line-count or field fault shifts the active lines. A half-line fault changes the shape of the composite sync or the placement of `vsync`. The bench predicts every output for every pixel of whole frames in both standards, so a fault is reported at the first pixel where it appears. A wrong reload at the frame wrap shows up at the first pixel of the next frame.

// File: rtl/sdtv_sync_gen.sv
module sdtv_sync_gen #(
  parameter int NTSC_LINES     = 525,
  parameter int PAL_LINES      = 625,
  parameter int NTSC_ACT_LINES = 240,
  parameter int PAL_ACT_LINES  = 288,
  parameter int H_SHIFT_W      = 4,
  parameter int V_SHIFT_W      = 9,
  parameter int CNT_W          = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic                 std_pal,
  input  logic [H_SHIFT_W-1:0] h_shift,
  input  logic [V_SHIFT_W-1:0] v_shift,
  output logic [CNT_W-1:0]     h_cnt,
  output logic [CNT_W-1:0]     v_cnt,
  output logic                 field,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 csync,
  output logic                 blank,
  output logic                 active,
  output logic                 burst_gate
);
  localparam int NT_HTOT   = 858;
  localparam int PL_HTOT   = 864;
  localparam int SYNC_W    = 64;
  localparam int EQ_W      = 32;
  localparam int SERR_W    = 64;
  localparam int BURST_W   = 34;
  localparam int NT_BREEZE = 8;
  localparam int PL_BREEZE = 12;
  localparam int ACT_PIX   = 720;
  localparam int NT_ACT0   = 112;
  localparam int PL_ACT0   = 118;
  localparam int NT_VBI    = 20;
  localparam int PL_VBI    = 22;
  localparam int NT_F1LINE = (NTSC_LINES + 1) / 2;
  localparam int PL_F1LINE = (PAL_LINES - 1) / 2;
  localparam int PL_F1PIX  = PL_HTOT / 2;
  localparam int HL_W      = 5;
  localparam logic [HL_W-1:0] HL_VS0 = HL_W'(6);
  localparam logic [HL_W-1:0] HL_VS1 = HL_W'(12);
  localparam logic [HL_W-1:0] HL_END = HL_W'(18);
  localparam int XW        = CNT_W + 1;

  logic              pal_q;
  logic [HL_W-1:0]   hl_q;
  logic [CNT_W-1:0]  h_tot, v_tot, half, f1_line, f1_pix, breeze, act0, vbi, act_lines;
  logic [CNT_W-1:0]  h_nxt, v_nxt, hh, lf;
  logic              h_last, v_last, fstart_nxt, half_nxt, in_vs, in_eq;
  logic [XW-1:0]     h_lo, h_hi, v_lo, v_hi;

  assign h_tot     = pal_q ? CNT_W'(PL_HTOT)       : CNT_W'(NT_HTOT);
  assign v_tot     = pal_q ? CNT_W'(PAL_LINES)     : CNT_W'(NTSC_LINES);
  assign half      = h_tot >> 1;
  assign f1_line   = pal_q ? CNT_W'(PL_F1LINE)     : CNT_W'(NT_F1LINE);
  assign f1_pix    = pal_q ? CNT_W'(PL_F1PIX)      : '0;
  assign breeze    = pal_q ? CNT_W'(PL_BREEZE)     : CNT_W'(NT_BREEZE);
  assign act0      = pal_q ? CNT_W'(PL_ACT0)       : CNT_W'(NT_ACT0);
  assign vbi       = pal_q ? CNT_W'(PL_VBI)        : CNT_W'(NT_VBI);
  assign act_lines = pal_q ? CNT_W'(PAL_ACT_LINES) : CNT_W'(NTSC_ACT_LINES);

  assign h_last     = (h_cnt == h_tot - 1'b1);
  assign v_last     = (v_cnt == v_tot - 1'b1);
  assign h_nxt      = h_last ? '0 : h_cnt + 1'b1;
  assign v_nxt      = h_last ? (v_last ? '0 : v_cnt + 1'b1) : v_cnt;
  assign fstart_nxt = (h_nxt == '0 && v_nxt == '0) || (h_nxt == f1_pix && v_nxt == f1_line);
  assign half_nxt   = (h_nxt == '0) || (h_nxt == half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
      field <= 1'b0;
      hl_q  <= '0;
      pal_q <= std_pal;
    end else if (pix_en) begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
      if (h_last && v_last) pal_q <= std_pal;
      if (fstart_nxt) begin
        hl_q  <= '0;
        field <= (v_nxt != '0);
      end else if (half_nxt && hl_q != HL_END) begin
        hl_q <= hl_q + 1'b1;
      end
    end
  end

  assign hh    = (h_cnt >= half) ? h_cnt - half : h_cnt;
  assign lf    = field ? v_cnt - f1_line : v_cnt;
  assign in_vs = (hl_q >= HL_VS0) && (hl_q < HL_VS1);
  assign in_eq = !in_vs && (hl_q < HL_END);

  assign hsync = (h_cnt < CNT_W'(SYNC_W));
  assign vsync = in_vs;
  assign csync = in_vs ? (hh < half - CNT_W'(SERR_W)) :
                 in_eq ? (hh < CNT_W'(EQ_W)) : hsync;

  assign burst_gate = (hl_q == HL_END) &&
                      (h_cnt >= CNT_W'(SYNC_W) + breeze) &&
                      (h_cnt <  CNT_W'(SYNC_W + BURST_W) + breeze);

  assign h_lo = XW'(act0) + XW'(h_shift);
  assign h_hi = h_lo + XW'(ACT_PIX);
  assign v_lo = XW'(vbi) + XW'(v_shift);
  assign v_hi = v_lo + XW'(act_lines);

  assign active = (XW'(h_cnt) >= h_lo) && (XW'(h_cnt) < h_hi) &&
                  (XW'(lf) >= v_lo) && (XW'(lf) < v_hi);
  assign blank  = !active;
endmodule

// File: rtl/sdtv_sync_gen_chk.sv
module sdtv_sync_gen_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [CNT_W-1:0] h_cnt,
  input logic [CNT_W-1:0] v_cnt,
  input logic             field,
  input logic             hsync,
  input logic             vsync,
  input logic             csync,
  input logic             blank,
  input logic             active,
  input logic             burst_gate
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_cnt) && $stable(v_cnt)));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt < CNT_W'(864)) && (v_cnt < CNT_W'(625)));

  p_hsync_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (h_cnt == '0));

  p_burst_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> (blank && !csync));

  p_field_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (h_cnt == '0 || h_cnt == CNT_W'(432)));

  p_vsync_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (blank && !burst_gate));

  p_active_nosync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (!csync && !hsync && !burst_gate));
endmodule

bind sdtv_sync_gen sdtv_sync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .field(field), .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
  .active(active), .burst_gate(burst_gate)
);

// File: tb/sdtv_sync_gen_tb_top.sv
`timescale 1ns/1ps
module sdtv_sync_gen_tb_top;
  localparam int NT_L = 55;
  localparam int PL_L = 61;
  localparam int NT_A = 6;
  localparam int PL_A = 6;

  logic clk = 1'b0;
  logic rst_n, pix_en, std_pal;
  logic [3:0] h_shift;
  logic [8:0] v_shift;
  logic [9:0] h_cnt, v_cnt;
  logic field, hsync, vsync, csync, blank, active, burst_gate;

  int checks = 0;
  int errors = 0;
  int bh = 0;
  int bv = 0;

  always #10 clk = ~clk;

  sdtv_sync_gen #(
    .NTSC_LINES(NT_L), .PAL_LINES(PL_L),
    .NTSC_ACT_LINES(NT_A), .PAL_ACT_LINES(PL_A)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .std_pal(std_pal),
    .h_shift(h_shift), .v_shift(v_shift), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .field(field), .hsync(hsync), .vsync(vsync), .csync(csync),
    .blank(blank), .active(active), .burst_gate(burst_gate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at h=%0d v=%0d: got %0d expected %0d", req, bh, bv, act, exp);
    end
  endtask

  task automatic compare_pos(input bit pal, input int hs, input int vs);
    int ht, half, f1l, f1h, hidx, fsidx, hl, hh, brz, a0, lf, vb0, al;
    bit fld, e_vs, e_eq, e_hs, e_cs, e_bu, e_act;
    ht    = pal ? 864 : 858;
    half  = ht / 2;
    f1l   = pal ? (PL_L - 1) / 2 : (NT_L + 1) / 2;
    f1h   = pal ? 432 : 0;
    fld   = (bv > f1l) || (bv == f1l && bh >= f1h);
    hidx  = 2 * bv + ((bh >= half) ? 1 : 0);
    fsidx = fld ? 2 * f1l + ((f1h != 0) ? 1 : 0) : 0;
    hl    = hidx - fsidx;
    if (hl > 18) hl = 18;
    hh    = (bh >= half) ? bh - half : bh;
    e_vs  = (hl >= 6) && (hl < 12);
    e_eq  = !e_vs && (hl < 18);
    e_hs  = bh < 64;
    e_cs  = e_vs ? (hh < half - 64) : (e_eq ? (hh < 32) : e_hs);
    brz   = pal ? 12 : 8;
    e_bu  = (hl >= 18) && (bh >= 64 + brz) && (bh < 98 + brz);
    a0    = (pal ? 118 : 112) + hs;
    lf    = fld ? bv - f1l : bv;
    vb0   = (pal ? 22 : 20) + vs;
    al    = pal ? PL_A : NT_A;
    e_act = (bh >= a0) && (bh < a0 + 720) && (lf >= vb0) && (lf < vb0 + al);
    chk("R2 h_cnt", int'(h_cnt), bh);
    chk("R2 v_cnt", int'(v_cnt), bv);
    chk("R7 field", int'(field), int'(fld));
    chk("R3 hsync", int'(hsync), int'(e_hs));
    chk("R8 vsync", int'(vsync), int'(e_vs));
    chk("R9 csync", int'(csync), int'(e_cs));
    chk("R4 burst_gate", int'(burst_gate), int'(e_bu));
    chk("R5 R6 active", int'(active), int'(e_act));
    chk("R10 blank", int'(blank), int'(!e_act));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pix_en = 1'b1; std_pal = 1'b0; h_shift = '0; v_shift = '0;
    repeat (4) @(negedge clk);
    chk("R1 h_cnt in reset", int'(h_cnt), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 h_cnt", int'(h_cnt), 0);
    chk("R1 v_cnt", int'(v_cnt), 0);
    chk("R1 field", int'(field), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 burst_gate", int'(burst_gate), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 hsync", int'(hsync), 1);
    chk("R1 csync", int'(csync), 1);
    chk("R1 blank", int'(blank), 1);
    bh = 0; bv = 0;
  endtask

  task automatic t_frame(input bit pal, input int hs, input int vs, input bit next_pal);
    int ht, lines, total;
    ht    = pal ? 864 : 858;
    lines = pal ? PL_L : NT_L;
    total = ht * lines;
    h_shift = 4'(hs);
    v_shift = 9'(vs);
    for (int n = 0; n < total; n++) begin
      if (n == total / 2) std_pal = next_pal;
      #1;
      compare_pos(pal, hs, vs);
      if (n == total - 1) chk("R11 last pixel of frame", int'(h_cnt), ht - 1);
      @(negedge clk);
      if (bh == ht - 1) begin
        bh = 0;
        bv = (bv == lines - 1) ? 0 : bv + 1;
      end else begin
        bh = bh + 1;
      end
    end
  endtask

  task automatic t_hold;
    logic [9:0] h0, v0;
    #1;
    h0 = h_cnt; v0 = v_cnt;
    pix_en = 1'b0;
    repeat (8) @(negedge clk);
    #1;
    chk("R2 h_cnt held", int'(h_cnt), int'(h0));
    chk("R2 v_cnt held", int'(v_cnt), int'(v0));
    pix_en = 1'b1;
    @(negedge clk);
    #1;
    chk("R2 h_cnt resumes", int'(h_cnt), int'(h0) + 1);
  endtask

  initial begin
    #(20ns * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(1'b0, 0, 0, 1'b1);
    t_frame(1'b1, 15, 3, 1'b0);
    t_frame(1'b0, 7, 500, 1'b0);
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule